// File: doc/BRIEF.md
# Strobe-Ordered Power Rail Sequencer

This block switches a group of power rails on and off in an order that software can change. Each rail has a 4-bit slot code. The code places the rail in one of seven numbered strobes, or it leaves the rail outside sequencer control. Each strobe has its own 2-bit wait code. The wait is counted in pulses of a free-running millisecond tick.

A start request makes the block climb from strobe 1 to strobe 7. At each strobe it waits that strobe's delay and then enables every rail mapped to it. A stop request makes it descend from strobe 7 to strobe 1, disabling the mapped rails in the same way. A stop that arrives during a climb aborts the climb and descends from the strobe that was pending. Rails outside sequencer control are driven straight from a software enable vector. A one-cycle done pulse marks the end of either walk.

Top module: `seq_rail_sequencer`

## Requirements
- R1: A slot code from 1 to 7 (binary 0001 to 0111) assigns the rail to that strobe. Several rails that share a code switch together in the same cycle.
- R2: Slot code 0 and codes 8 to 15 leave a rail uncontrolled. Such a rail's output equals its bit of `sw_rail_en` in the same cycle, and strobes never change it.
- R3: After an accepted start, the strobes fire in ascending order 1 to 7. Each firing sets the outputs of the rails mapped to that strobe, and rails already on stay on.
- R4: The wait before each strobe is counted in `ms_tick` pulses from the moment that strobe becomes pending. Wait code 0, 1, 2 and 3 means 1, 2, 5 and 10 ticks. Strobe s uses bits [2s-1:2s-2] of `strobe_dly`.
- R5: After an accepted stop from idle, the strobes fire in descending order 7 to 1. Each firing clears the outputs of the rails mapped to that strobe, and each strobe uses its own wait code.
- R6: A stop during a climb abandons the pending strobe without enabling its rails. The descent begins at that strobe, with a fresh wait.
- R7: `seq_done` is high for exactly one cycle, in the cycle after the last strobe of a climb (7) or a descent (1) fires. It is low at all other times.
- R8: A start while a walk is running is ignored. A stop while descending is ignored. Neither changes the strobe position or the wait count.
- R9: A start and a stop in the same cycle from idle begin a descent. A stop in the same cycle as the tick that would fire a climbing strobe wins, and that strobe's rails stay off.
- R10: After reset the block is idle, all controlled rails are off and `seq_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| start_req | input | 1 | Power-up request pulse |
| stop_req | input | 1 | Power-down request pulse |
| rail_slot | input | NUM_RAILS*4 | Slot code per rail; rail r in bits [4r+3:4r] |
| strobe_dly | input | NUM_STROBES*2 | Wait code per strobe; strobe s in bits [2s-1:2s-2] |
| sw_rail_en | input | NUM_RAILS | Direct enables for uncontrolled rails |
| rail_en | output | NUM_RAILS | Rail enable outputs |
| seq_done | output | 1 | One-cycle end-of-walk pulse |

## Verification
Two events can fall in the same clock cycle: a stop request, and the tick that makes a climbing strobe fire. The same holds for a start and a stop that both arrive while idle. The bench raises the stop together with the expiring tick. It then checks that the pending strobe's rail stays off and that the descent takes exactly as many ticks as the strobes left below it. For the idle case it raises both requests together and requires that no rail turns on and that the done pulse comes after a full descent.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int SLOT_W = 4;
  localparam int DLY_W  = 2;
  localparam int TMR_W  = 4;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_UP   = 2'd1,
    SQ_DOWN = 2'd2
  } seq_mode_t;

  // tick count for a wait code
  function automatic logic [TMR_W-1:0] dly_ticks(input logic [DLY_W-1:0] code);
    case (code)
      2'd0:    dly_ticks = TMR_W'(1);
      2'd1:    dly_ticks = TMR_W'(2);
      2'd2:    dly_ticks = TMR_W'(5);
      default: dly_ticks = TMR_W'(10);
    endcase
  endfunction

  // a slot code is under sequencer control only inside 1..nstb
  function automatic logic slot_valid(input logic [SLOT_W-1:0] code, input int unsigned nstb);
    slot_valid = (code != '0) && (32'(code) <= nstb);
  endfunction
endpackage

// File: rtl/seq_slot_decode.sv
module seq_slot_decode
  import seq_pkg::*;
#(
  parameter int NUM_RAILS   = 7,
  parameter int NUM_STROBES = 7
) (
  input  logic [NUM_RAILS*SLOT_W-1:0] rail_slot,
  input  logic [SLOT_W-1:0]           cur_strobe,
  output logic [NUM_RAILS-1:0]        ctrl_mask,
  output logic [NUM_RAILS-1:0]        hit_mask
);
  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
    logic [SLOT_W-1:0] code;
    assign code         = rail_slot[r*SLOT_W +: SLOT_W];
    assign ctrl_mask[r] = slot_valid(code, NUM_STROBES);
    assign hit_mask[r]  = ctrl_mask[r] && (code == cur_strobe);
  end
endmodule

// File: rtl/seq_delay_timer.sv
module seq_delay_timer
  import seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic             ms_tick,
  input  logic [DLY_W-1:0] dly_code,
  output logic             expire
);
  logic [TMR_W-1:0] tick_cnt;
  logic [TMR_W-1:0] target;

  assign target = dly_ticks(dly_code);
  assign expire = run && ms_tick && (tick_cnt == target - TMR_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              tick_cnt <= '0;
    else if (restart)        tick_cnt <= '0;
    else if (run && ms_tick) tick_cnt <= tick_cnt + TMR_W'(1);
  end
endmodule

// File: rtl/seq_step_ctrl.sv
module seq_step_ctrl
  import seq_pkg::*;
#(
  parameter int NUM_STROBES = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              stop_req,
  input  logic              expire,
  output seq_mode_t         mode,
  output logic [SLOT_W-1:0] cur_strobe,
  output logic              fire_on,
  output logic              fire_off,
  output logic              restart,
  output logic              done
);
  localparam logic [SLOT_W-1:0] LAST_STB  = SLOT_W'(NUM_STROBES);
  localparam logic [SLOT_W-1:0] FIRST_STB = SLOT_W'(1);

  logic start_acc, stop_acc;

  assign start_acc = (mode == SQ_IDLE) && start_req && !stop_req;
  assign stop_acc  = stop_req && (mode != SQ_DOWN);
  assign fire_on   = (mode == SQ_UP) && expire && !stop_req;
  assign fire_off  = (mode == SQ_DOWN) && expire;
  assign restart   = start_acc || stop_acc || fire_on || fire_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= SQ_IDLE;
      cur_strobe <= FIRST_STB;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (stop_acc) begin
        mode <= SQ_DOWN;
        if (mode == SQ_IDLE) cur_strobe <= LAST_STB;
      end else if (start_acc) begin
        mode       <= SQ_UP;
        cur_strobe <= FIRST_STB;
      end else if (fire_on) begin
        if (cur_strobe == LAST_STB) begin
          mode <= SQ_IDLE;
          done <= 1'b1;
        end else begin
          cur_strobe <= cur_strobe + SLOT_W'(1);
        end
      end else if (fire_off) begin
        if (cur_strobe == FIRST_STB) begin
          mode <= SQ_IDLE;
          done <= 1'b1;
        end else begin
          cur_strobe <= cur_strobe - SLOT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/seq_rail_sequencer.sv
module seq_rail_sequencer
  import seq_pkg::*;
#(
  parameter int NUM_RAILS   = 7,
  parameter int NUM_STROBES = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ms_tick,
  input  logic                          start_req,
  input  logic                          stop_req,
  input  logic [NUM_RAILS*SLOT_W-1:0]   rail_slot,
  input  logic [NUM_STROBES*DLY_W-1:0]  strobe_dly,
  input  logic [NUM_RAILS-1:0]          sw_rail_en,
  output logic [NUM_RAILS-1:0]          rail_en,
  output logic                          seq_done
);
  seq_mode_t           mode;
  logic [SLOT_W-1:0]   cur_strobe;
  logic                fire_on, fire_off, restart, expire, run;
  logic [NUM_RAILS-1:0] ctrl_mask, hit_mask, seq_on;
  logic [DLY_W-1:0]    cur_dly;

  assign run = (mode != SQ_IDLE);

  // wait code of the pending strobe
  always_comb begin
    cur_dly = '0;
    for (int s = 0; s < NUM_STROBES; s++)
      if (cur_strobe == SLOT_W'(s + 1)) cur_dly = strobe_dly[s*DLY_W +: DLY_W];
  end

  seq_slot_decode #(.NUM_RAILS(NUM_RAILS), .NUM_STROBES(NUM_STROBES)) u_dec (
    .rail_slot (rail_slot),
    .cur_strobe(cur_strobe),
    .ctrl_mask (ctrl_mask),
    .hit_mask  (hit_mask)
  );

  seq_delay_timer u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .run     (run),
    .ms_tick (ms_tick),
    .dly_code(cur_dly),
    .expire  (expire)
  );

  seq_step_ctrl #(.NUM_STROBES(NUM_STROBES)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .stop_req  (stop_req),
    .expire    (expire),
    .mode      (mode),
    .cur_strobe(cur_strobe),
    .fire_on   (fire_on),
    .fire_off  (fire_off),
    .restart   (restart),
    .done      (seq_done)
  );

  // held rail state; an uncontrolled rail tracks software so a later
  // takeover starts from the level the rail already had
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_on <= '0;
    end else begin
      for (int r = 0; r < NUM_RAILS; r++) begin
        if (!ctrl_mask[r])                  seq_on[r] <= sw_rail_en[r];
        else if (fire_on  && hit_mask[r])   seq_on[r] <= 1'b1;
        else if (fire_off && hit_mask[r])   seq_on[r] <= 1'b0;
      end
    end
  end

  assign rail_en = (seq_on & ctrl_mask) | (sw_rail_en & ~ctrl_mask);
endmodule

// File: rtl/seq_rail_sequencer_chk.sv
module seq_rail_sequencer_chk #(
  parameter int NUM_STROBES = 7
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_req,
  input logic       stop_req,
  input logic       expire,
  input logic [1:0] mode,
  input logic [3:0] cur_strobe,
  input logic       fire_on,
  input logic       fire_off,
  input logic       seq_done
);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  // R3
  climb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_on |=> (cur_strobe == $past(cur_strobe) + 4'd1) || (seq_done && mode == 2'd0));

  // R5
  descend_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_off |=> (cur_strobe == $past(cur_strobe) - 4'd1) || (seq_done && mode == 2'd0));

  // R9
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (mode == 2'd2) || seq_done);

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0 && start_req && !stop_req && !expire) |=>
      (cur_strobe == $past(cur_strobe)) && (mode == $past(mode)));

  // R1
  strobe_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0) |-> (cur_strobe >= 4'd1) && (32'(cur_strobe) <= NUM_STROBES));
endmodule

bind seq_rail_sequencer seq_rail_sequencer_chk #(.NUM_STROBES(NUM_STROBES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_req (start_req),
  .stop_req  (stop_req),
  .expire    (expire),
  .mode      (mode),
  .cur_strobe(cur_strobe),
  .fire_on   (fire_on),
  .fire_off  (fire_off),
  .seq_done  (seq_done)
);

// File: tb/tb_seq_rail_sequencer.sv
module tb_seq_rail_sequencer;
  localparam int NR = 7;
  localparam int NS = 7;
  localparam int TK[4] = '{1, 2, 5, 10};

  logic clk = 0, rst_n = 0, ms_tick = 0, start_req = 0, stop_req = 0;
  logic [NR*4-1:0] rail_slot;
  logic [NS*2-1:0] strobe_dly;
  logic [NR-1:0]   sw_rail_en = '0;
  logic [NR-1:0]   rail_en;
  logic            seq_done;
  logic [3:0] slot_cfg [NR];
  logic [1:0] dly_cfg  [NS];
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  always_comb begin
    for (int r = 0; r < NR; r++) rail_slot[r*4 +: 4] = slot_cfg[r];
    for (int s = 0; s < NS; s++) strobe_dly[s*2 +: 2] = dly_cfg[s];
  end

  seq_rail_sequencer dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; start_req = 0; stop_req = 0; ms_tick = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask
  task automatic tick();
    @(negedge clk) ms_tick = 1;
    @(negedge clk) ms_tick = 0;
  endtask
  task automatic pulse_start();
    @(negedge clk) start_req = 1;
    @(negedge clk) start_req = 0;
  endtask
  task automatic pulse_stop();
    @(negedge clk) stop_req = 1;
    @(negedge clk) stop_req = 0;
  endtask

  function automatic bit is_ctrl(input logic [3:0] c);
    return (c >= 4'd1) && (c <= 4'd7);
  endfunction
  function automatic int on_time(input int s);
    int t = 0;
    for (int k = 0; k < s; k++) t += TK[dly_cfg[k]];
    return t;
  endfunction
  function automatic int off_time(input int s);
    int t = 0;
    for (int k = NS - 1; k >= s - 1; k--) t += TK[dly_cfg[k]];
    return t;
  endfunction
  function automatic logic [NR-1:0] exp_rails(input int t, input bit up);
    logic [NR-1:0] e = '0;
    for (int r = 0; r < NR; r++) begin
      if (!is_ctrl(slot_cfg[r])) e[r] = sw_rail_en[r];
      else if (up)  e[r] = (on_time(int'(slot_cfg[r])) <= t);
      else          e[r] = (off_time(int'(slot_cfg[r])) > t);
    end
    return e;
  endfunction

  // R3 R4 R1 R2 R7: full climb against computed fire times
  task automatic climb_check(input string tag);
    int total = on_time(NS);
    pulse_start();
    for (int t = 1; t <= total; t++) begin
      tick();
      chk({tag, " R3/R4 rails"}, 32'(rail_en), 32'(exp_rails(t, 1)));
      chk({tag, " R7 done"}, 32'(seq_done), 32'(t == total));
    end
    @(negedge clk);
    chk({tag, " R7 done one cycle"}, 32'(seq_done), 0);
  endtask

  // R5 R7: full descent from idle
  task automatic descend_check(input string tag);
    int total = off_time(1);
    pulse_stop();
    for (int t = 1; t <= total; t++) begin
      tick();
      chk({tag, " R5 rails"}, 32'(rail_en), 32'(exp_rails(t, 0)));
      chk({tag, " R7 done"}, 32'(seq_done), 32'(t == total));
    end
  endtask

  task automatic t_reset();
    for (int r = 0; r < NR; r++) slot_cfg[r] = 4'(r + 1);
    for (int s = 0; s < NS; s++) dly_cfg[s] = 2'd0;
    sw_rail_en = '0;
    do_reset();
    chk("R10 rails off", 32'(rail_en), 0);
    chk("R10 done low", 32'(seq_done), 0);
  endtask

  task automatic t_plain();
    t_reset();
    climb_check("plain");
    descend_check("plain");
  endtask

  task automatic t_mixed();
    slot_cfg = '{4'd2, 4'd5, 4'd0, 4'd2, 4'd9, 4'd15, 4'd7};
    dly_cfg  = '{2'd1, 2'd3, 2'd2, 2'd0, 2'd1, 2'd0, 2'd0};
    sw_rail_en = 7'b0110101;
    do_reset();
    chk("R2 uncontrolled follow sw", 32'(rail_en), 32'(7'b0110100));
    sw_rail_en[4] = 0;
    #1 chk("R2 sw change seen", 32'(rail_en), 32'(7'b0100100));
    climb_check("mixed");
    descend_check("mixed");
  endtask

  task automatic t_abort();
    t_reset();
    pulse_start();
    repeat (3) tick();
    chk("R6 before stop", 32'(rail_en), 32'(7'b0000111));
    pulse_stop();
    tick();
    chk("R6 pending strobe stays off", 32'(rail_en), 32'(7'b0000111));
    tick();
    chk("R6 descend 3", 32'(rail_en), 32'(7'b0000011));
    tick();
    chk("R6 descend 2", 32'(rail_en), 32'(7'b0000001));
    chk("R7 no early done", 32'(seq_done), 0);
    tick();
    chk("R6 descend 1", 32'(rail_en), 0);
    chk("R7 done after abort", 32'(seq_done), 1);
  endtask

  task automatic t_both_idle();
    t_reset();
    @(negedge clk) begin start_req = 1; stop_req = 1; end
    @(negedge clk) begin start_req = 0; stop_req = 0; end
    for (int t = 1; t <= NS; t++) begin
      tick();
      chk("R9 start+stop gives descent", 32'(rail_en), 0);
      chk("R9 done timing", 32'(seq_done), 32'(t == NS));
    end
  endtask

  task automatic t_stop_on_tick();
    t_reset();
    pulse_start();
    repeat (2) tick();
    @(negedge clk) begin ms_tick = 1; stop_req = 1; end
    @(negedge clk) begin ms_tick = 0; stop_req = 0; end
    chk("R9 strobe 3 not fired", 32'(rail_en), 32'(7'b0000011));
    tick();
    chk("R9 descend from 3", 32'(rail_en), 32'(7'b0000011));
    tick();
    chk("R9 descend 2", 32'(rail_en), 32'(7'b0000001));
    tick();
    chk("R9 descend 1", 32'(rail_en), 0);
    chk("R9 done", 32'(seq_done), 1);
  endtask

  task automatic t_ignored();
    t_reset();
    pulse_start();
    tick();
    pulse_start();
    tick();
    chk("R8 start during climb ignored", 32'(rail_en), 32'(7'b0000011));
    pulse_stop();
    pulse_start();
    pulse_stop();
    tick();
    chk("R8 descend 3", 32'(rail_en), 32'(7'b0000011));
    tick();
    chk("R8 descend 2", 32'(rail_en), 32'(7'b0000001));
    tick();
    chk("R8 descend 1", 32'(rail_en), 0);
    chk("R8 done position kept", 32'(seq_done), 1);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_plain();
    t_mixed();
    t_abort();
    t_both_idle();
    t_stop_on_tick();
    t_ignored();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule